// File: doc/BRIEF.md
# Memory-Mapped SPI Master Controller

This block is a host-programmed SPI master. Software loads a word into a small transmit queue through a write-only port. It picks the target, the data directions and the bus mode, then writes the control word with the start bit set. Each start shifts exactly one word of 1 to 32 bits onto MOSI, most significant bit first. The bits captured on MISO are pushed into a small receive queue, where software later collects them through a read port.

The serial clock is the system clock divided by a fixed parameter. Its resting level and sampling phase are set from the control word. Four active-low chip-select lines are provided. Either software owns the chosen line through a level bit, or the controller asserts it for the duration of each transfer. Sticky error and done flags live in a status word and are cleared by writing ones to them. A second status word gives the fill counts of both queues.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, status (offset 0x08) reads 0x00A00000 (only RX-empty bit 23 and TX-empty bit 21 set), status2 (0x1C) reads 0, all four cs_n lines are high and sclk is low.
- R2: A control write (0x00) with enable bit 31, start bit 30 and master bit 28 set launches one transfer of exactly len+1 bits, where len is bits 4:0. Busy (status bit 31) reads 1 from the next read after that write until the transfer ends, and bit 30 of the control word reads 0 once the transfer is finished.
- R3: MOSI carries bits len..0 of the transmit entry, most significant bit first.
- R4: With clock phase bit 21 at 0, data is sampled on the leading clock edge; with it at 1, data is sampled on the trailing edge. sclk rests at bit 24 of the control word (the idle field is bits 25:24; codes 1 and 3 rest high, 0 and 2 rest low).
- R5: The received word is right-aligned in the receive entry and its bits above len are zero.
- R6: When a transfer ends, ready (status bit 30) is set. Writing 1 to bit 30 clears it, and writing 0 leaves it set.
- R7: With transmit enable (control2 bit 30) clear, MOSI stays 0 and the transmit queue is not popped. With receive enable (control2 bit 31) clear, no receive entry is written.
- R8: A start with transmit enabled and an empty transmit queue sets underrun (status bit 24) and shifts zeros.
- R9: A write to a full transmit port is dropped and sets bit 19. A finished transfer that finds the receive queue full drops its word and sets bit 25. A read of the empty receive port returns 0 and sets bit 18.
- R10: Status bit 29 is the OR of the four sticky bits 25, 24, 19 and 18, each of which clears when 1 is written to it.
- R11: Status2 bits 5:0 give the transmit fill count and bits 21:16 the receive fill count. Status bits 20 and 22 flag a full transmit and receive queue (4 entries each).
- R12: With software select (control bit 11) set, control bit 12 at 1 drives cs_n[k] low and the other lines high, where k is control2 bits 19:18; at 0 all lines are high. With bit 11 clear, cs_n[k] is low only while a transfer runs.
- R13: Both queues return words in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench sweeps every length from 1 to 32 bits in all four clock modes with MISO looped to MOSI. An off-by-one in the length field would show up as a wrong edge count. A missed leading or trailing edge would put a shifted word in the receive queue. A left-aligned receive word would leave stray upper bits. Separate sequences fill the transmit queue past capacity and drain it through transfers into a full receive queue. A design that overwrote entries instead of dropping them, or that set the wrong sticky bit, would break the read-back order or the flag pattern. Disabled directions, software and automatic chip select on each line, and write-one-to-clear with both ones and zeros are each checked at the pins or through the status registers.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_W = 32;

  // register offsets
  localparam logic [8:0] OFF_CTRL  = 9'h000;
  localparam logic [8:0] OFF_CTRL2 = 9'h004;
  localparam logic [8:0] OFF_STAT  = 9'h008;
  localparam logic [8:0] OFF_STAT2 = 9'h01C;
  localparam logic [8:0] OFF_TXQ   = 9'h100;
  localparam logic [8:0] OFF_RXQ   = 9'h180;

  // control word bit positions
  localparam int B_EN     = 31;
  localparam int B_GO     = 30;
  localparam int B_MAST   = 28;
  localparam int B_IDLE   = 24;
  localparam int B_PHASE  = 21;
  localparam int B_CSLVL  = 12;
  localparam int B_CSSW   = 11;

  // control2 bit positions
  localparam int B_RXON   = 31;
  localparam int B_TXON   = 30;
  localparam int B_SEL    = 18;

  // status bit positions
  localparam int S_BUSY   = 31;
  localparam int S_RDY    = 30;
  localparam int S_ERR    = 29;
  localparam int S_RXOVF  = 25;
  localparam int S_TXUNR  = 24;
  localparam int S_RXMT   = 23;
  localparam int S_RXFUL  = 22;
  localparam int S_TXMT   = 21;
  localparam int S_TXFUL  = 20;
  localparam int S_TXOVF  = 19;
  localparam int S_RXUNR  = 18;

  localparam int CNT_RX_LSB = 16;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               wdata,
  output logic [W-1:0]               rdata,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH) + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R13
  push_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int CLK_DIV = 2,
  parameter int W       = 32,
  parameter int LEN_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [W-1:0]     tx_word,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_word,
  output logic             sclk,
  output logic             mosi
);
  localparam int HC_W = $clog2(CLK_DIV + 1);
  localparam int EC_W = LEN_W + 1;

  logic [HC_W-1:0] hc;
  logic [EC_W-1:0] edge_i, edge_last;
  logic            pha_q;
  logic [W-1:0]    tsr, rsr, load;
  logic            leading, sample;

  assign load    = tx_word << (LEN_W'(W - 1) - len);
  assign leading = ~edge_i[0];
  assign sample  = pha_q ? ~leading : leading;
  assign rx_word = rsr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      hc        <= '0;
      edge_i    <= '0;
      edge_last <= '0;
      pha_q     <= 1'b0;
      tsr       <= '0;
      rsr       <= '0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        if (start) begin
          busy      <= 1'b1;
          hc        <= '0;
          edge_i    <= '0;
          edge_last <= {len, 1'b1};
          pha_q     <= cpha;
          rsr       <= '0;
          if (!cpha) begin
            mosi <= load[W-1];
            tsr  <= load << 1;
          end else begin
            mosi <= 1'b0;
            tsr  <= load;
          end
        end
      end else if (hc == HC_W'(CLK_DIV - 1)) begin
        hc   <= '0;
        sclk <= ~sclk;
        if (sample) begin
          rsr <= {rsr[W-2:0], miso};
        end else if (edge_i != edge_last) begin
          mosi <= tsr[W-1];
          tsr  <= tsr << 1;
        end
        if (edge_i == edge_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          edge_i <= edge_i + 1'b1;
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!busy) |-> (sclk == $past(cpol)));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
  parameter int ADDR_W     = 9,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 2,
  parameter int NUM_CS     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  import spim_pkg::*;

  localparam int W     = REG_W;
  localparam int LEN_W = $clog2(W);
  localparam int SEL_W = $clog2(NUM_CS);
  localparam int CW    = $clog2(FIFO_DEPTH) + 1;

  // control state
  logic             c_en, c_go, c_mast, c_pha, c_cslvl, c_cssw;
  logic [1:0]       c_idle;
  logic [LEN_W-1:0] c_len;
  logic             c2_rx, c2_tx;
  logic [SEL_W-1:0] c2_sel;

  // sticky flags
  logic rdy_q, rxovf_q, txunr_q, txovf_q, rxunr_q;

  // decode
  logic wr_ctrl, wr_ctrl2, wr_stat, wr_tx, rd_rx;
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_ctrl2 = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL2));
  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_tx    = bus_wr && (bus_addr == ADDR_W'(OFF_TXQ));
  assign rd_rx    = bus_rd && (bus_addr == ADDR_W'(OFF_RXQ));

  // queues
  logic [W-1:0]  tx_head, rx_head, eng_rx;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          eng_busy, eng_done, start, tx_pop, rx_push;
  logic [W-1:0]  eng_tx;

  assign start   = c_go && !eng_busy && c_en && c_mast;
  assign tx_pop  = start && c2_tx && !tx_empty;
  assign eng_tx  = tx_pop ? tx_head : '0;
  assign rx_push = eng_done && c2_rx && !rx_full;

  spim_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(wr_tx), .pop(tx_pop), .wdata(bus_wdata),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_cnt));

  spim_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .pop(rd_rx), .wdata(eng_rx),
    .rdata(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_cnt));

  spim_shifter #(.CLK_DIV(CLK_DIV), .W(W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst(rst), .start(start), .len(c_len), .cpol(c_idle[0]),
    .cpha(c_pha), .tx_word(eng_tx), .miso(miso), .busy(eng_busy),
    .done(eng_done), .rx_word(eng_rx), .sclk(sclk), .mosi(mosi));

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      c_en <= 1'b0; c_go <= 1'b0; c_mast <= 1'b0; c_pha <= 1'b0;
      c_cslvl <= 1'b0; c_cssw <= 1'b0; c_idle <= '0; c_len <= '0;
      c2_rx <= 1'b0; c2_tx <= 1'b0; c2_sel <= '0;
    end else begin
      if (wr_ctrl) begin
        c_en    <= bus_wdata[B_EN];
        c_mast  <= bus_wdata[B_MAST];
        c_idle  <= bus_wdata[B_IDLE +: 2];
        c_pha   <= bus_wdata[B_PHASE];
        c_cslvl <= bus_wdata[B_CSLVL];
        c_cssw  <= bus_wdata[B_CSSW];
        c_len   <= bus_wdata[LEN_W-1:0];
      end
      if (start)                              c_go <= 1'b0;
      else if (wr_ctrl && bus_wdata[B_GO])    c_go <= 1'b1;
      if (wr_ctrl2) begin
        c2_rx  <= bus_wdata[B_RXON];
        c2_tx  <= bus_wdata[B_TXON];
        c2_sel <= bus_wdata[B_SEL +: SEL_W];
      end
    end
  end

  // sticky flags: set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b0; rxovf_q <= 1'b0; txunr_q <= 1'b0;
      txovf_q <= 1'b0; rxunr_q <= 1'b0;
    end else begin
      if (eng_done)                           rdy_q <= 1'b1;
      else if (wr_stat && bus_wdata[S_RDY])   rdy_q <= 1'b0;
      if (eng_done && c2_rx && rx_full)       rxovf_q <= 1'b1;
      else if (wr_stat && bus_wdata[S_RXOVF]) rxovf_q <= 1'b0;
      if (start && c2_tx && tx_empty)         txunr_q <= 1'b1;
      else if (wr_stat && bus_wdata[S_TXUNR]) txunr_q <= 1'b0;
      if (wr_tx && tx_full)                   txovf_q <= 1'b1;
      else if (wr_stat && bus_wdata[S_TXOVF]) txovf_q <= 1'b0;
      if (rd_rx && rx_empty)                  rxunr_q <= 1'b1;
      else if (wr_stat && bus_wdata[S_RXUNR]) rxunr_q <= 1'b0;
    end
  end

  // read-back words
  logic [31:0] ctrl_v, ctrl2_v, stat_v, stat2_v;
  always_comb begin
    ctrl_v = '0;
    ctrl_v[B_EN]         = c_en;
    ctrl_v[B_GO]         = c_go;
    ctrl_v[B_MAST]       = c_mast;
    ctrl_v[B_IDLE +: 2]  = c_idle;
    ctrl_v[B_PHASE]      = c_pha;
    ctrl_v[B_CSLVL]      = c_cslvl;
    ctrl_v[B_CSSW]       = c_cssw;
    ctrl_v[LEN_W-1:0]    = c_len;

    ctrl2_v = '0;
    ctrl2_v[B_RXON]        = c2_rx;
    ctrl2_v[B_TXON]        = c2_tx;
    ctrl2_v[B_SEL +: SEL_W] = c2_sel;

    stat_v = '0;
    stat_v[S_BUSY]  = eng_busy || c_go;
    stat_v[S_RDY]   = rdy_q;
    stat_v[S_ERR]   = rxovf_q || txunr_q || txovf_q || rxunr_q;
    stat_v[S_RXOVF] = rxovf_q;
    stat_v[S_TXUNR] = txunr_q;
    stat_v[S_RXMT]  = rx_empty;
    stat_v[S_RXFUL] = rx_full;
    stat_v[S_TXMT]  = tx_empty;
    stat_v[S_TXFUL] = tx_full;
    stat_v[S_TXOVF] = txovf_q;
    stat_v[S_RXUNR] = rxunr_q;

    stat2_v = '0;
    stat2_v[CW-1:0]              = tx_cnt;
    stat2_v[CNT_RX_LSB +: CW]    = rx_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFF_CTRL):  bus_rdata <= ctrl_v;
        ADDR_W'(OFF_CTRL2): bus_rdata <= ctrl2_v;
        ADDR_W'(OFF_STAT):  bus_rdata <= stat_v;
        ADDR_W'(OFF_STAT2): bus_rdata <= stat2_v;
        ADDR_W'(OFF_RXQ):   bus_rdata <= rx_empty ? '0 : rx_head;
        default:            bus_rdata <= '0;
      endcase
    end
  end

  // chip selects
  logic cs_on;
  assign cs_on = c_cssw ? c_cslvl : eng_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n <= '1;
    end else begin
      for (int k = 0; k < NUM_CS; k++)
        cs_n[k] <= !(cs_on && (c2_sel == SEL_W'(k)));
    end
  end

  // R12
  cs_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R6
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(eng_done));

  // R9
  txovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(txovf_q) |-> $past(wr_tx && tx_full));
endmodule

// File: tb/sim_spim_ctrl.sv
module sim_spim_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  cs_n;
  logic        loop_on = 1'b1;
  logic        miso_lvl = 1'b0;

  int tests = 0, fails = 0;
  int cycles = 0;

  // monitor state
  logic        mon_pol = 1'b0, mon_pha = 1'b0, prev_sclk = 1'b0;
  logic [31:0] cap = '0;
  int          ncap = 0;

  localparam logic [8:0] A_CTRL = 9'h000, A_CTRL2 = 9'h004, A_STAT = 9'h008,
                         A_STAT2 = 9'h01C, A_TXQ = 9'h100, A_RXQ = 9'h180;

  assign miso = loop_on ? mosi : miso_lvl;

  always #5 clk = ~clk;

  spim_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always @(negedge clk) begin
    if (sclk !== prev_sclk) begin
      if ((prev_sclk == mon_pol) == !mon_pha) begin
        cap  = {cap[30:0], mosi};
        ncap = ncap + 1;
      end
    end
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 1000; i++) begin
      rd(A_STAT, s);
      if (!s[31]) break;
    end
  endtask

  // start one transfer; push_word controls whether a TX entry is loaded
  task automatic xfer(input int len, input bit pha, input logic [1:0] idle,
                      input logic [31:0] w, input bit txon, input bit rxon,
                      input bit push_word, input logic [31:0] csbits);
    wr(A_CTRL2, {rxon, txon, 30'b0} | (32'(0) << 18));
    if (push_word) wr(A_TXQ, w);
    cap = '0; ncap = 0; mon_pol = idle[0]; mon_pha = pha;
    wr(A_CTRL, 32'hD000_0000 | (32'(idle) << 24) | (32'(pha) << 21) |
               csbits | 32'(len));
    wait_idle();
  endtask

  function automatic logic [31:0] lmask(input int len);
    return 32'hFFFF_FFFF >> (31 - len);
  endfunction

  initial begin
    logic [31:0] d, w, s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, d);  chk(d == 32'h00A0_0000, "R1 status", d, 32'h00A0_0000);
    rd(A_STAT2, d); chk(d == 32'h0, "R1 status2", d, 32'h0);
    chk(cs_n == 4'hF && sclk == 1'b0, "R1 pins", {26'b0, cs_n, sclk, mosi},
        32'h0000_003C);

    // R2 R3 R4 R5 sweep: every length, every mode, loopback
    for (int len = 0; len < 32; len++) begin
      for (int m = 0; m < 4; m++) begin
        w = 32'hA5C3_96E1 ^ (32'(len) * 32'h0101_0101) ^ 32'(m * 7);
        xfer(len, m[0], {1'b0, m[1]}, w, 1'b1, 1'b1, 1'b1, 32'h0);
        chk(ncap == len + 1, "R2 edge count", 32'(ncap), 32'(len + 1));
        chk(cap == (w & lmask(len)), "R3 mosi order", cap, w & lmask(len));
        chk(sclk == m[1], "R4 idle level", {31'b0, sclk}, {31'b0, m[1]});
        rd(A_RXQ, d);
        chk(d == (w & lmask(len)), "R4 R5 rx word", d, w & lmask(len));
      end
    end

    // R4 pull codes 2 and 3 rest like 0 and 1
    xfer(7, 1'b0, 2'd3, 32'h5A, 1'b1, 1'b1, 1'b1, 32'h0);
    chk(sclk == 1'b1, "R4 code3 idle", {31'b0, sclk}, 32'h1);
    rd(A_RXQ, d);
    xfer(7, 1'b1, 2'd2, 32'h5A, 1'b1, 1'b1, 1'b1, 32'h0);
    chk(sclk == 1'b0, "R4 code2 idle", {31'b0, sclk}, 32'h0);
    rd(A_RXQ, d);

    // R5 all-ones MISO right-aligned
    loop_on = 1'b0; miso_lvl = 1'b1;
    xfer(11, 1'b1, 2'd0, 32'h0, 1'b1, 1'b1, 1'b1, 32'h0);
    rd(A_RXQ, d);
    chk(d == 32'h0000_0FFF, "R5 right aligned", d, 32'h0000_0FFF);
    loop_on = 1'b1;

    // R2 busy right after start, start bit self-clears
    wr(A_CTRL2, 32'hC000_0000);
    wr(A_TXQ, 32'h1234_5678);
    wr(A_CTRL, 32'hD000_001F);
    rd(A_STAT, d);
    chk(d[31] == 1'b1, "R2 busy after start", d, d | 32'h8000_0000);
    wait_idle();
    rd(A_CTRL, d);
    chk(d[30] == 1'b0, "R2 start self-clear", d, d & ~32'h4000_0000);
    rd(A_RXQ, d);

    // R6 ready W1C
    rd(A_STAT, d);
    chk(d[30] == 1'b1, "R6 ready set", d, d | 32'h4000_0000);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d);
    chk(d[30] == 1'b1, "R6 write zero keeps", d, d | 32'h4000_0000);
    wr(A_STAT, 32'h4000_0000);
    rd(A_STAT, d);
    chk(d[30] == 1'b0, "R6 write one clears", d, d & ~32'h4000_0000);

    // R7 transmit disabled: mosi zero, entry kept
    wr(A_TXQ, 32'hFFFF_FFFF);
    xfer(15, 1'b0, 2'd0, 32'h0, 1'b0, 1'b1, 1'b0, 32'h0);
    chk(cap == 32'h0, "R7 tx off mosi", cap, 32'h0);
    rd(A_STAT2, d);
    chk(d == 32'h0001_0001, "R7 tx off keeps entry", d, 32'h0001_0001);
    rd(A_RXQ, d);
    // R7 receive disabled: no entry
    xfer(15, 1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 1'b0, 32'h0);
    rd(A_STAT2, d);
    chk(d == 32'h0, "R7 rx off no entry", d, 32'h0);
    chk(cap == 32'h0000_FFFF, "R13 queued word sent", cap, 32'h0000_FFFF);

    // R8 underrun with empty TX queue
    loop_on = 1'b1;
    xfer(7, 1'b0, 2'd0, 32'h0, 1'b1, 1'b1, 1'b0, 32'h0);
    rd(A_STAT, d);
    chk(d[24] && d[29], "R8 underrun flag", d, d | 32'h2100_0000);
    chk(cap == 32'h0, "R8 zeros shifted", cap, 32'h0);
    rd(A_RXQ, d);
    wr(A_STAT, 32'h0100_0000);
    rd(A_STAT, d);
    chk(!d[24] && !d[29], "R10 clear underrun", d, d & ~32'h2100_0000);

    // R9 R11 R13 overflow and ordering
    for (int i = 0; i < 5; i++) wr(A_TXQ, 32'h100 + 32'(i));
    rd(A_STAT, d);
    chk(d[19] && d[20] && d[29], "R9 tx overflow", d, d | 32'h2018_0000);
    rd(A_STAT2, d);
    chk(d == 32'h0000_0004, "R11 tx count", d, 32'h0000_0004);
    for (int i = 0; i < 5; i++)
      xfer(15, 1'b0, 2'd0, 32'h0, 1'b1, 1'b1, 1'b0, 32'h0);
    rd(A_STAT, d);
    chk(d[25] && d[22] && d[24], "R9 rx overflow", d, d | 32'h0340_0000);
    rd(A_STAT2, d);
    chk(d == 32'h0004_0000, "R11 rx count", d, 32'h0004_0000);
    for (int i = 0; i < 4; i++) begin
      rd(A_RXQ, d);
      chk(d == 32'h100 + 32'(i), "R13 order", d, 32'h100 + 32'(i));
    end
    rd(A_RXQ, d);
    chk(d == 32'h0, "R9 empty read", d, 32'h0);
    rd(A_STAT, d);
    chk(d[18], "R9 rx underrun", d, d | 32'h0004_0000);
    wr(A_STAT, 32'h030C_0000);
    rd(A_STAT, d);
    chk(d == 32'h00A0_0000 || d == 32'h40A0_0000, "R10 all cleared", d,
        32'h40A0_0000);

    // R12 software chip select on each line
    for (int k = 0; k < 4; k++) begin
      wr(A_CTRL2, 32'(k) << 18);
      wr(A_CTRL, 32'h9000_1800);
      @(negedge clk);
      chk(cs_n == ~(4'b1 << k), "R12 soft select", {28'b0, cs_n},
          {28'b0, ~(4'b1 << k)});
      wr(A_CTRL, 32'h9000_0800);
      @(negedge clk);
      chk(cs_n == 4'hF, "R12 soft release", {28'b0, cs_n}, 32'hF);
    end
    // R12 automatic select during a transfer
    wr(A_CTRL2, 32'hC000_0000 | (32'd2 << 18));
    wr(A_TXQ, 32'h0);
    wr(A_CTRL, 32'hD000_001F);
    repeat (6) @(negedge clk);
    chk(cs_n == 4'b1011, "R12 auto select", {28'b0, cs_n}, 32'hB);
    wait_idle();
    @(negedge clk);
    chk(cs_n == 4'hF, "R12 auto release", {28'b0, cs_n}, 32'hF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule